// File: doc/BRIEF.md
# Parallel EEPROM Page-Load Write Controller

This block is the write front end of a byte-wide parallel EEPROM with a 19-bit address. It watches a host bus whose chip-enable, output-enable and write-enable lines are all active low. It turns each qualified write strobe into one byte placed in a page-sized staging buffer, and each buffer slot has a flag that records whether it was loaded. The first accepted byte fixes the page. Later bytes must carry the same page bits and may arrive in any order, and a later byte can replace an earlier one.

Loading ends when no new byte has arrived within a programmable gap. The block then enters a self-timed programming period. During that period it is busy, it ignores every strobe, and it issues one commit strobe per loaded byte, in ascending offset order, to the storage array that sits behind it. Before a power-on delay has elapsed, no write is taken. A strobe whose page bits differ from those of the current load is dropped and sets a sticky error flag.

Top module: `eeprom_page_loader`

## Requirements
- R1: A write cycle only occurs while chip-enable and write-enable are both low and output-enable is high. The byte is taken when that condition ends because chip-enable or write-enable rises. A strobe made with output-enable low, or one during which output-enable falls, has no effect.
- R2: The address is the one present when the later of the two enables falls. The data is the value present in the last cycle before the first of the two enables rises.
- R3: No strobe that completes within the first POR_CYCLES clock cycles after reset is accepted.
- R4: A load ends when GAP_CYCLES cycles pass without an accepted byte. Bytes spaced closer than that join the same load, and programming (busy) starts about GAP_CYCLES cycles after the last accepted byte.
- R5: A strobe whose address bits 18:8 differ from those of the first byte of the current load is ignored. It also sets page_err, which stays high until reset.
- R6: Only loaded offsets are committed, each once, with its most recent data. Commits come one per cycle in ascending order of offset bits 7:0, and each commit address carries the load's page bits 18:8.
- R7: busy is high for exactly PROG_CYCLES cycles per programming period. Strobes made while busy are ignored.
- R8: last_addr and last_data show the address and data of the most recently accepted byte.
- R9: A load of all 256 offsets of one page produces 256 commits.
- R10: After reset, busy, page_err, commit_valid, last_addr and last_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; low blocks writes |
| we_n | input | 1 | Write enable, active low |
| addr | input | 19 | Byte address; bits 18:8 are the page, bits 7:0 the offset |
| din | input | 8 | Write data |
| busy | output | 1 | High during the self-timed programming period |
| page_err | output | 1 | Sticky flag for a strobe aimed at a different page |
| last_addr | output | 19 | Address of the last accepted byte |
| last_data | output | 8 | Data of the last accepted byte |
| commit_valid | output | 1 | One-cycle strobe per committed byte |
| commit_addr | output | 19 | Address of the committed byte |
| commit_data | output | 8 | Data of the committed byte |

## Verification
The bench changes the address after the enable falls and the data just before it rises. A controller that latched either value at the wrong edge would commit a junk address or stale data. Several corner cases are exercised:
- Out-of-order loads with a rewritten offset: a design that lost its slot flags, or replayed every write, would emit duplicate, unloaded or out-of-order commits.
- A foreign-page strobe inside a load: a design that failed to reject it would commit that byte or leave page_err low.
- Strobes with output-enable low, strobes made while busy, and strobes made before the power-on delay: a weak write qualifier would show these as a changed last_addr or as extra commits.

// File: rtl/pgl_pkg.sv
package pgl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } ld_state_t;
endpackage

// File: rtl/pgl_bus_qual.sv
// Registers the host bus and turns enable edges into write events.
module pgl_bus_qual #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_start,
  output logic              wr_done,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data
);
  logic              ce_q, oe_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  logic              act, act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b1;
      oe_q   <= 1'b1;
      we_q   <= 1'b1;
      addr_q <= '0;
      din_q  <= '0;
      act_d  <= 1'b0;
    end else begin
      ce_q   <= ce_n;
      oe_q   <= oe_n;
      we_q   <= we_n;
      addr_q <= addr;
      din_q  <= din;
      act_d  <= act;
    end
  end

  // write window: both enables low, output enable high
  assign act      = ~ce_q & ~we_q & oe_q;
  // later falling enable opens the window
  assign wr_start = act & ~act_d;
  // first rising enable closes it; output enable dropping aborts it
  assign wr_done  = act_d & ~act & oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      if (wr_start) cap_addr <= addr_q;
      if (act)      cap_data <= din_q;
    end
  end
endmodule

// File: rtl/pgl_timer.sv
// Saturating up-counter with synchronous clear.
module pgl_timer #(
  parameter int LIMIT = 1,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                count <= '0;
    else if (clr)                              count <= '0;
    else if (en && (count != W'(LIMIT)))       count <= count + 1'b1;
  end
endmodule

// File: rtl/pgl_page_buf.sv
// Page staging buffer with one loaded flag per byte slot.
module pgl_page_buf #(
  parameter int OFS_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFS_W-1:0]  rd_ofs,
  input  logic              rd_clr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SLOTS = 1 << OFS_W;

  logic [DATA_W-1:0] slot_data [SLOTS];
  logic              slot_vld  [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        slot_vld[g] <= 1'b0;
      else if (wr_en && (wr_ofs == OFS_W'(g)))           slot_vld[g] <= 1'b1;
      else if (rd_clr && (rd_ofs == OFS_W'(g)))          slot_vld[g] <= 1'b0;
    end
    always_ff @(posedge clk) begin
      if (wr_en && (wr_ofs == OFS_W'(g))) slot_data[g] <= wr_data;
    end
  end

  assign rd_valid = slot_vld[rd_ofs];
  assign rd_data  = slot_data[rd_ofs];
endmodule

// File: rtl/eeprom_page_loader.sv
module eeprom_page_loader #(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8,
  parameter int OFS_W       = 8,
  parameter int GAP_CYCLES  = 15000,
  parameter int PROG_CYCLES = 1000000,
  parameter int POR_CYCLES  = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic              page_err,
  output logic [ADDR_W-1:0] last_addr,
  output logic [DATA_W-1:0] last_data,
  output logic              commit_valid,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  import pgl_pkg::*;

  localparam int PAGE_W     = ADDR_W - OFS_W;
  localparam int PAGE_BYTES = 1 << OFS_W;
  localparam int GAP_W      = $clog2(GAP_CYCLES);
  localparam int PROG_W     = $clog2(PROG_CYCLES);
  localparam int POR_W      = $clog2(POR_CYCLES);

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFS_W];
  endfunction

  function automatic logic [OFS_W-1:0] ofs_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W-1:0];
  endfunction

  ld_state_t         state;
  logic [PAGE_W-1:0] page_reg;

  logic              wr_start, wr_done;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;

  logic [GAP_W-1:0]  gap_cnt;
  logic [PROG_W-1:0] prog_cnt;
  logic [POR_W-1:0]  por_cnt;

  // named internal events, observed by the checker
  logic              por_done, wr_ok, page_hit, accept, mismatch, expire;
  logic              prog_done, scan_live;
  logic [OFS_W-1:0]  scan_ofs;
  logic              buf_valid;
  logic [DATA_W-1:0] buf_data;

  pgl_bus_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .wr_start(wr_start), .wr_done(wr_done),
    .cap_addr(cap_addr), .cap_data(cap_data)
  );

  pgl_timer #(.LIMIT(POR_CYCLES - 1), .W(POR_W)) u_por (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .en(~por_done), .count(por_cnt)
  );

  pgl_timer #(.LIMIT(GAP_CYCLES - 1), .W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .clr(accept | (state != ST_LOAD)),
    .en(state == ST_LOAD), .count(gap_cnt)
  );

  pgl_timer #(.LIMIT(PROG_CYCLES - 1), .W(PROG_W)) u_prog (
    .clk(clk), .rst_n(rst_n), .clr(state != ST_PROG),
    .en(state == ST_PROG), .count(prog_cnt)
  );

  pgl_page_buf #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_ofs(ofs_of(cap_addr)),
    .wr_data(cap_data), .rd_ofs(scan_ofs), .rd_clr(commit_valid),
    .rd_valid(buf_valid), .rd_data(buf_data)
  );

  assign por_done  = (por_cnt == POR_W'(POR_CYCLES - 1));
  assign wr_ok     = wr_done & por_done;
  assign page_hit  = (page_of(cap_addr) == page_reg);
  assign accept    = wr_ok & ((state == ST_IDLE) | ((state == ST_LOAD) & page_hit));
  assign mismatch  = wr_ok & (state == ST_LOAD) & ~page_hit;
  assign expire    = (state == ST_LOAD) & ~accept & (gap_cnt == GAP_W'(GAP_CYCLES - 1));
  assign prog_done = (state == ST_PROG) & (prog_cnt == PROG_W'(PROG_CYCLES - 1));

  assign scan_live = (state == ST_PROG) & (prog_cnt < PROG_W'(PAGE_BYTES));
  assign scan_ofs  = prog_cnt[OFS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      page_reg  <= '0;
      page_err  <= 1'b0;
      last_addr <= '0;
      last_data <= '0;
    end else begin
      if (accept) begin
        last_addr <= cap_addr;
        last_data <= cap_data;
        if (state == ST_IDLE) page_reg <= page_of(cap_addr);
      end
      if (mismatch) page_err <= 1'b1;
      unique case (state)
        ST_IDLE: if (accept)    state <= ST_LOAD;
        ST_LOAD: if (expire)    state <= ST_PROG;
        ST_PROG: if (prog_done) state <= ST_IDLE;
        default:                state <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state == ST_PROG);
  assign commit_valid = scan_live & buf_valid;
  assign commit_addr  = {page_reg, scan_ofs};
  assign commit_data  = buf_data;
endmodule

// File: rtl/pgl_checker.sv
module pgl_checker #(
  parameter int ADDR_W = 19,
  parameter int OFS_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              expire,
  input logic              por_done,
  input logic              busy,
  input logic              page_err,
  input logic              commit_valid,
  input logic [ADDR_W-1:0] commit_addr
);
  // R3
  por_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> por_done);
  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);
  // R4
  expire_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> busy);
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);
  // R6
  commit_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> busy);
  // R6
  commit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && $past(commit_valid)) |->
      (commit_addr[OFS_W-1:0] > $past(commit_addr[OFS_W-1:0])));
  // R6
  commit_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && $past(commit_valid)) |->
      (commit_addr[ADDR_W-1:OFS_W] == $past(commit_addr[ADDR_W-1:OFS_W])));
endmodule

bind eeprom_page_loader pgl_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .expire(expire),
  .por_done(por_done), .busy(busy), .page_err(page_err),
  .commit_valid(commit_valid), .commit_addr(commit_addr)
);

// File: tb/sim_eeprom_page_loader.sv
`timescale 1ns/1ps
module sim_eeprom_page_loader;
  localparam int GAP  = 20;
  localparam int PROG = 300;
  localparam int POR  = 40;
  localparam int SETTLE = GAP + PROG + 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [18:0] addr = '0;
  logic [7:0]  din = '0;
  logic        busy, page_err, commit_valid;
  logic [18:0] last_addr, commit_addr;
  logic [7:0]  last_data, commit_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  eeprom_page_loader #(.GAP_CYCLES(GAP), .PROG_CYCLES(PROG), .POR_CYCLES(POR)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .busy(busy), .page_err(page_err),
    .last_addr(last_addr), .last_data(last_data), .commit_valid(commit_valid),
    .commit_addr(commit_addr), .commit_data(commit_data)
  );

  // commit and busy monitor, sampled away from the active edge
  logic [18:0] c_addr [0:511];
  logic [7:0]  c_data [0:511];
  logic [18:0] e_addr [0:511];
  logic [7:0]  e_data [0:511];
  int c_n = 0;
  int busy_cyc = 0;
  int busy_rise = 0;
  logic busy_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (commit_valid && c_n < 512) begin
        c_addr[c_n] = commit_addr;
        c_data[c_n] = commit_data;
        c_n = c_n + 1;
      end
      if (busy) busy_cyc = busy_cyc + 1;
      if (busy && !busy_prev) busy_rise = busy_rise + 1;
      busy_prev = busy;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    c_n = 0; busy_cyc = 0; busy_rise = 0;
  endtask

  task automatic check_commits(input string req, input int n);
    check(req, "commit count", c_n, n);
    for (int i = 0; i < n && i < c_n; i++) begin
      check(req, "commit addr", int'(c_addr[i]), int'(e_addr[i]));
      check(req, "commit data", int'(c_data[i]), int'(e_data[i]));
    end
  endtask

  // write-enable controlled strobe; address moved after the fall, data moved late
  task automatic wr_we(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = ~d; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); addr = a ^ 19'h7FFFF;
    @(negedge clk); din = d;
    @(negedge clk); we_n = 1'b1; din = 8'h5A;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
  endtask

  // chip-enable controlled strobe: write enable falls first
  task automatic wr_ce(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk); addr = 19'h0; din = d; we_n = 1'b0;
    @(negedge clk); addr = a;
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); addr = 19'h7FFFF;
    @(negedge clk);
    @(negedge clk); ce_n = 1'b1; din = 8'h00;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10", "busy", busy, 0);
    check("R10", "page_err", page_err, 0);
    check("R10", "commit_valid", commit_valid, 0);
    check("R10", "last_addr", last_addr, 0);
    check("R10", "last_data", last_data, 0);
  endtask

  task automatic t_early();
    clear_mon();
    wr_we(19'h01234, 8'h77);
    repeat (GAP + 5) @(negedge clk);
    check("R3", "last_addr after early write", last_addr, 0);
    check("R3", "busy after early write", busy, 0);
    check("R3", "commits after early write", c_n, 0);
    repeat (POR) @(negedge clk);
  endtask

  task automatic t_single();
    int wait_cyc;
    clear_mon();
    wr_we(19'h12345, 8'hA5);
    check("R8", "last_addr", last_addr, 19'h12345);
    check("R2", "last_data (late data)", last_data, 8'hA5);
    check("R4", "busy while loading", busy, 0);
    wait_cyc = 0;
    while (!busy && wait_cyc < GAP + 50) begin @(negedge clk); wait_cyc++; end
    checks++;
    if (wait_cyc < GAP - 6 || wait_cyc > GAP + 2) begin
      errors++;
      $display("FAIL R4 busy start delay: actual %0d expected %0d..%0d", wait_cyc, GAP - 6, GAP + 2);
    end
    repeat (SETTLE) @(negedge clk);
    check("R7", "busy cycles", busy_cyc, PROG);
    check("R7", "busy after programming", busy, 0);
    e_addr[0] = 19'h12345; e_data[0] = 8'hA5;
    check_commits("R6", 1);
  endtask

  task automatic t_page();
    clear_mon();
    wr_we({11'h3A1, 8'h80}, 8'h11);
    wr_we({11'h3A1, 8'h05}, 8'h22);
    wr_we({11'h3A1, 8'hFF}, 8'h33);
    wr_we({11'h3A1, 8'h05}, 8'h44);
    wr_we({11'h3A1, 8'h00}, 8'h55);
    check("R8", "last_addr after page", last_addr, {11'h3A1, 8'h00});
    repeat (SETTLE) @(negedge clk);
    check("R4", "one programming period", busy_rise, 1);
    e_addr[0] = {11'h3A1, 8'h00}; e_data[0] = 8'h55;
    e_addr[1] = {11'h3A1, 8'h05}; e_data[1] = 8'h44;
    e_addr[2] = {11'h3A1, 8'h80}; e_data[2] = 8'h11;
    e_addr[3] = {11'h3A1, 8'hFF}; e_data[3] = 8'h33;
    check_commits("R6", 4);
  endtask

  task automatic t_ce();
    clear_mon();
    wr_ce(19'h4C0DE, 8'h9C);
    check("R2", "ce-controlled last_addr", last_addr, 19'h4C0DE);
    check("R2", "ce-controlled last_data", last_data, 8'h9C);
    repeat (SETTLE) @(negedge clk);
    e_addr[0] = 19'h4C0DE; e_data[0] = 8'h9C;
    check_commits("R2", 1);
  endtask

  task automatic t_inhibit();
    clear_mon();
    // output enable low for the whole strobe
    @(negedge clk); addr = 19'h00111; din = 8'hEE; oe_n = 1'b0; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "last_addr after oe-low strobe", last_addr, 19'h4C0DE);
    // output enable drops in the middle of a strobe
    @(negedge clk); addr = 19'h00222; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk);
    @(negedge clk); oe_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "last_addr after aborted strobe", last_addr, 19'h4C0DE);
    // write enable pulse with chip enable high
    @(negedge clk); addr = 19'h00333; we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "last_addr after ce-high pulse", last_addr, 19'h4C0DE);
    repeat (GAP + 10) @(negedge clk);
    check("R1", "busy after inhibited strobes", busy, 0);
    check("R1", "commits after inhibited strobes", c_n, 0);
  endtask

  task automatic t_mismatch();
    clear_mon();
    wr_we({11'h015, 8'h01}, 8'hA1);
    wr_we({11'h016, 8'h02}, 8'hB2);
    check("R5", "page_err after foreign page", page_err, 1);
    check("R5", "last_addr after foreign page", last_addr, {11'h015, 8'h01});
    wr_we({11'h015, 8'h03}, 8'hC3);
    repeat (SETTLE) @(negedge clk);
    check("R5", "page_err sticky", page_err, 1);
    e_addr[0] = {11'h015, 8'h01}; e_data[0] = 8'hA1;
    e_addr[1] = {11'h015, 8'h03}; e_data[1] = 8'hC3;
    check_commits("R5", 2);
  endtask

  task automatic t_busy();
    clear_mon();
    wr_we(19'h2AA10, 8'h3C);
    repeat (GAP + 10) @(negedge clk);
    check("R7", "busy before strobe", busy, 1);
    wr_we(19'h2AA20, 8'hC3);
    check("R7", "last_addr after busy strobe", last_addr, 19'h2AA10);
    repeat (SETTLE) @(negedge clk);
    check("R7", "single programming period", busy_rise, 1);
    e_addr[0] = 19'h2AA10; e_data[0] = 8'h3C;
    check_commits("R7", 1);
  endtask

  task automatic t_gap();
    clear_mon();
    wr_we(19'h05501, 8'h01);
    repeat (GAP + 10) @(negedge clk);
    wr_we(19'h05502, 8'h02);
    repeat (2 * SETTLE) @(negedge clk);
    // second byte arrives during the first programming period and is dropped
    check("R4", "programming periods after late byte", busy_rise, 1);
    e_addr[0] = 19'h05501; e_data[0] = 8'h01;
    check_commits("R4", 1);
  endtask

  task automatic t_full();
    clear_mon();
    for (int i = 255; i >= 0; i--) wr_we({11'h7F0, 8'(i)}, 8'(i ^ 8'hC5));
    repeat (SETTLE) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      e_addr[i] = {11'h7F0, 8'(i)};
      e_data[i] = 8'(i ^ 8'hC5);
    end
    check_commits("R9", 256);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_early();
    t_single();
    t_page();
    t_ce();
    t_inhibit();
    t_mismatch();
    t_busy();
    t_gap();
    t_full();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule